// File: doc/BRIEF.md
# Windowed Pixel Address Generator

This block turns a stream of pixel-write strobes into display-RAM write addresses. A host first sets a rectangular window through a byte-wide configuration port: its left and right columns, its top and bottom lines, the line stride (the number of pixels in one memory line) and an optional linear base address. After that, every strobe on the pixel input produces one RAM write on the next clock edge. The write lands at the current cursor position, and the cursor then moves one step through the window in raster order.

The cursor walks right along a line. After the right edge it returns to the left edge one line lower. After the bottom-right corner it returns to the top-left corner. Software can therefore stream pixels without ever sending a coordinate. The linear address is the base plus the line times the stride plus the column, kept to the RAM address width. The RAM itself and the read-side scan are outside the block.

Top module: `win_addr_gen`

## Requirements
- R1: After reset, `ram_we_o` is low and `ram_addr_o` is 0. The window covers columns 0 to 319 and lines 0 to 239, the stride is 320, the base is 0 and the cursor sits at column 0, line 0.
- R2: A pixel strobe sampled on a clock edge gives exactly one cycle of `ram_we_o` after that edge. Without a strobe, `ram_we_o` is low and `ram_addr_o` holds its value.
- R3: The emitted address is (base + line * stride + column) mod 2^18, using the cursor and the settings in force on the strobe edge.
- R4: Inside a line, each strobe advances the column by one.
- R5: A strobe while the column equals the right edge, and the line does not equal the bottom, moves the cursor to the left edge of the next line.
- R6: A strobe while the cursor is at the right edge and the bottom line moves the cursor to the left edge of the top line.
- R7: A write to any of the eight window bytes (indices 0x00 to 0x07) puts the cursor at the window's left edge and top line, using the newly written values.
- R8: Writes to the stride bytes (0x08 and 0x09) or the base bytes (0x0A to 0x0C) leave the cursor where it is. They affect only the address computed for the following strobes.
- R9: When a configuration write and a strobe share an edge, the strobe is served with the old cursor and old settings. If the write targets the window, the cursor then restarts at the new window start.
- R10: Configuration map. Each 10-bit field is split into a low byte at an even index, holding bits [7:0], and bits [9:8] in data bits [1:0] of the next odd index. Left edge is 0x00/0x01, right edge 0x02/0x03, top 0x04/0x05, bottom 0x06/0x07 and stride 0x08/0x09. The base is split over three indices: 0x0A holds bits [7:0], 0x0B holds [15:8] and 0x0C holds [17:16] in data bits [1:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_addr_i | input | 8 | Configuration byte index |
| cfg_wdata_i | input | 8 | Configuration byte value |
| pix_valid_i | input | 1 | One pixel write requested this cycle |
| ram_addr_o | output | 18 | Display-RAM write address |
| ram_we_o | output | 1 | Display-RAM write enable |

## Verification
A configuration write and a pixel strobe can land on the same edge. The pixel must then use the pre-write cursor and settings, while a window write must still restart the cursor for the next pixel. The bench drives both inputs in one cycle twice. The first time the write is a window byte: the bench expects the old-position address, and then the new window start on the next strobe. The second time the write is a base byte: the bench expects the cursor to carry on and the next address to include the new base. The scoreboard model computes each expected address from the register values before the write, and applies the write only afterwards.

// File: rtl/win_addr_pkg.sv
package win_addr_pkg;
  localparam int unsigned NUM_FLD   = 5;
  localparam int unsigned FLD_X0    = 0;
  localparam int unsigned FLD_X1    = 1;
  localparam int unsigned FLD_Y0    = 2;
  localparam int unsigned FLD_Y1    = 3;
  localparam int unsigned FLD_STR   = 4;
  localparam logic [7:0]  WIN_LAST  = 8'h07;
  localparam logic [7:0]  BASE_B0   = 8'h0A;
  localparam logic [7:0]  BASE_B1   = 8'h0B;
  localparam logic [7:0]  BASE_B2   = 8'h0C;
endpackage

// File: rtl/win_addr_regs.sv
module win_addr_regs
  import win_addr_pkg::*;
#(
  parameter int unsigned CW         = 10,
  parameter int unsigned AW         = 18,
  parameter int unsigned X0_RST     = 0,
  parameter int unsigned X1_RST     = 319,
  parameter int unsigned Y0_RST     = 0,
  parameter int unsigned Y1_RST     = 239,
  parameter int unsigned STRIDE_RST = 320
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_i,
  input  logic [7:0]                     addr_i,
  input  logic [7:0]                     data_i,
  output logic [NUM_FLD-1:0][CW-1:0]     fld_q_o,
  output logic [NUM_FLD-1:0][CW-1:0]     fld_d_o,
  output logic [AW-1:0]                  base_o,
  output logic                           win_wr_o
);
  localparam int unsigned HW  = CW - 8;
  localparam int unsigned BHW = AW - 16;
  localparam logic [NUM_FLD-1:0][CW-1:0] FLD_RST =
    {CW'(STRIDE_RST), CW'(Y1_RST), CW'(Y0_RST), CW'(X1_RST), CW'(X0_RST)};

  for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
    logic [CW-1:0] q, d;
    always_comb begin
      d = q;
      if (wr_i && addr_i == 8'(2*i))   d[7:0]    = data_i;
      if (wr_i && addr_i == 8'(2*i+1)) d[CW-1:8] = data_i[HW-1:0];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= FLD_RST[i];
      else         q <= d;
    end
    assign fld_q_o[i] = q;
    assign fld_d_o[i] = d;
  end

  logic [AW-1:0] base_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
    end else if (wr_i) begin
      case (addr_i)
        BASE_B0: base_q[7:0]     <= data_i;
        BASE_B1: base_q[15:8]    <= data_i;
        BASE_B2: base_q[AW-1:16] <= data_i[BHW-1:0];
        default: ;
      endcase
    end
  end
  assign base_o   = base_q;
  assign win_wr_o = wr_i && (addr_i <= WIN_LAST);

  // R8: base only moves through its own bytes
  assert_base_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && (addr_i == BASE_B0 || addr_i == BASE_B1 || addr_i == BASE_B2))
      |=> $stable(base_o));
  // R10: a write outside the field map changes no field
  assert_fld_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i < 8'(2*NUM_FLD)) |=> $stable(fld_q_o));
endmodule

// File: rtl/win_addr_cursor.sv
module win_addr_cursor #(
  parameter int unsigned CW    = 10,
  parameter int unsigned X_RST = 0,
  parameter int unsigned Y_RST = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_i,
  input  logic          reload_i,
  input  logic [CW-1:0] x0_i,
  input  logic [CW-1:0] x1_i,
  input  logic [CW-1:0] y0_i,
  input  logic [CW-1:0] y1_i,
  input  logic [CW-1:0] x0_nxt_i,
  input  logic [CW-1:0] y0_nxt_i,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o
);
  logic [CW-1:0] x_q, y_q;
  logic x_end, y_end;

  assign x_end = (x_q == x1_i);
  assign y_end = (y_q == y1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= CW'(X_RST);
      y_q <= CW'(Y_RST);
    end else if (reload_i) begin
      // window write wins over advance
      x_q <= x0_nxt_i;
      y_q <= y0_nxt_i;
    end else if (pix_i) begin
      if (x_end) begin
        x_q <= x0_i;
        y_q <= y_end ? y0_i : y_q + CW'(1);
      end else begin
        x_q <= x_q + CW'(1);
      end
    end
  end
  assign x_o = x_q;
  assign y_o = y_q;

  assert_col_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_i && !reload_i && !x_end) |=> (x_q == $past(x_q) + CW'(1)) && $stable(y_q));
  assert_row_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_i && !reload_i && x_end && !y_end) |=> (x_q == x0_i) && (y_q == $past(y_q) + CW'(1)));
  assert_win_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_i && !reload_i && x_end && y_end) |=> (x_q == x0_i) && (y_q == y0_i));
  assert_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (x_q == x0_i) && (y_q == y0_i));
  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pix_i && !reload_i) |=> $stable(x_q) && $stable(y_q));
endmodule

// File: rtl/win_addr_calc.sv
module win_addr_calc #(
  parameter int unsigned CW = 10,
  parameter int unsigned AW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_i,
  input  logic [CW-1:0] x_i,
  input  logic [CW-1:0] y_i,
  input  logic [CW-1:0] stride_i,
  input  logic [AW-1:0] base_i,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_we_o
);
  logic [AW-1:0] lin;
  // modular arithmetic: truncation at AW bits equals wrap of the full sum
  assign lin = base_i + AW'(y_i) * AW'(stride_i) + AW'(x_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_addr_o <= '0;
      ram_we_o   <= 1'b0;
    end else begin
      ram_we_o <= pix_i;
      if (pix_i) ram_addr_o <= lin;
    end
  end

  assert_we_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_i |=> ram_we_o);
  assert_we_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_i |=> !ram_we_o && $stable(ram_addr_o));
endmodule

// File: rtl/win_addr_gen.sv
module win_addr_gen
  import win_addr_pkg::*;
#(
  parameter int unsigned CW         = 10,
  parameter int unsigned AW         = 18,
  parameter int unsigned X0_RST     = 0,
  parameter int unsigned X1_RST     = 319,
  parameter int unsigned Y0_RST     = 0,
  parameter int unsigned Y1_RST     = 239,
  parameter int unsigned STRIDE_RST = 320
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [7:0]    cfg_addr_i,
  input  logic [7:0]    cfg_wdata_i,
  input  logic          pix_valid_i,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_we_o
);
  logic [NUM_FLD-1:0][CW-1:0] fld_q, fld_d;
  logic [AW-1:0]              base;
  logic                       win_wr;
  logic [CW-1:0]              cur_x, cur_y;

  win_addr_regs #(
    .CW(CW), .AW(AW), .X0_RST(X0_RST), .X1_RST(X1_RST),
    .Y0_RST(Y0_RST), .Y1_RST(Y1_RST), .STRIDE_RST(STRIDE_RST)
  ) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .data_i  (cfg_wdata_i),
    .fld_q_o (fld_q),
    .fld_d_o (fld_d),
    .base_o  (base),
    .win_wr_o(win_wr)
  );

  win_addr_cursor #(.CW(CW), .X_RST(X0_RST), .Y_RST(Y0_RST)) i_cursor (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pix_i   (pix_valid_i),
    .reload_i(win_wr),
    .x0_i    (fld_q[FLD_X0]),
    .x1_i    (fld_q[FLD_X1]),
    .y0_i    (fld_q[FLD_Y0]),
    .y1_i    (fld_q[FLD_Y1]),
    .x0_nxt_i(fld_d[FLD_X0]),
    .y0_nxt_i(fld_d[FLD_Y0]),
    .x_o     (cur_x),
    .y_o     (cur_y)
  );

  win_addr_calc #(.CW(CW), .AW(AW)) i_calc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pix_i     (pix_valid_i),
    .x_i       (cur_x),
    .y_i       (cur_y),
    .stride_i  (fld_q[FLD_STR]),
    .base_i    (base),
    .ram_addr_o(ram_addr_o),
    .ram_we_o  (ram_we_o)
  );
endmodule

// File: tb/test_win_addr_gen.sv
module test_win_addr_gen;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        pix = 1'b0;
  logic [17:0] ram_addr;
  logic        ram_we;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [17:0] q_addr[$];
  string       q_tag[$];

  // reference model state
  logic [9:0]  mx0 = 10'd0, mx1 = 10'd319, my0 = 10'd0, my1 = 10'd239, mstr = 10'd320;
  logic [17:0] mbase = '0;
  logic [9:0]  cx = '0, cy = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_addr_gen i_win_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .pix_valid_i(pix), .ram_addr_o(ram_addr), .ram_we_o(ram_we)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] exp_addr();
    int unsigned s;
    s = int'(mbase) + int'(cy) * int'(mstr) + int'(cx);
    return s[17:0];
  endfunction

  function automatic void advance();
    if (cx == mx1) begin
      cx = mx0;
      cy = (cy == my1) ? my0 : cy + 10'd1;
    end else begin
      cx = cx + 10'd1;
    end
  endfunction

  function automatic void set_field(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h00: mx0[7:0] = d;   8'h01: mx0[9:8] = d[1:0];
      8'h02: mx1[7:0] = d;   8'h03: mx1[9:8] = d[1:0];
      8'h04: my0[7:0] = d;   8'h05: my0[9:8] = d[1:0];
      8'h06: my1[7:0] = d;   8'h07: my1[9:8] = d[1:0];
      8'h08: mstr[7:0] = d;  8'h09: mstr[9:8] = d[1:0];
      8'h0A: mbase[7:0] = d; 8'h0B: mbase[15:8] = d;
      8'h0C: mbase[17:16] = d[1:0];
      default: ;
    endcase
    if (a <= 8'h07) begin
      cx = mx0;
      cy = my0;
    end
  endfunction

  // one cycle of stimulus; pixel uses pre-write model state (R9)
  task automatic step(input bit p, input bit w, input logic [7:0] a,
                      input logic [7:0] d, input string tag);
    @(negedge clk);
    pix = p; cfg_we = w; cfg_addr = a; cfg_wdata = d;
    if (p) begin
      q_addr.push_back(exp_addr());
      q_tag.push_back(tag);
      advance();
    end
    if (w) set_field(a, d);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step(1'b0, 1'b1, a, d, "");
  endtask

  task automatic pixels(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 8'h00, 8'h00, tag);
  endtask

  task automatic idle_check(input string tag);
    step(1'b0, 1'b0, 8'h00, 8'h00, "");
    @(negedge clk);
    check(ram_we == 1'b0, tag, int'(ram_we), 0);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && ram_we) begin
        if (q_addr.size() == 0) begin
          check(1'b0, "R2 unexpected write", int'(ram_addr), 0);
        end else begin
          automatic logic [17:0] e = q_addr.pop_front();
          automatic string t = q_tag.pop_front();
          check(ram_addr == e, t, int'(ram_addr), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ram_we == 1'b0, "R1 we in reset", int'(ram_we), 0);
    check(ram_addr == 18'd0, "R1 addr in reset", int'(ram_addr), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ram_we == 1'b0, "R1 we after reset", int'(ram_we), 0);

    // R1/R4/R3: default window, start at 0
    pixels(5, "R4 default row");
    idle_check("R2 no strobe no write");

    // R7/R10: small window, each write reloads cursor
    wr(8'h00, 8'd10); wr(8'h02, 8'd12);
    wr(8'h04, 8'd3);  wr(8'h06, 8'd4);
    pixels(3, "R5 row before wrap");
    pixels(3, "R5 second row");
    pixels(2, "R6 window wrap");
    idle_check("R2 quiet after burst");

    // R8: stride write keeps cursor
    wr(8'h08, 8'h50);
    pixels(2, "R8 stride change");
    // R8/R3: base near top, truncation to 18 bits
    wr(8'h0A, 8'hFF); wr(8'h0B, 8'hFF); wr(8'h0C, 8'h03);
    pixels(4, "R3 modulo base");

    // R9: window write and pixel on the same edge
    step(1'b1, 1'b1, 8'h00, 8'd11, "R9 old position");
    pixels(2, "R9 new start");
    // R9: base write and pixel on the same edge
    step(1'b1, 1'b1, 8'h0A, 8'h00, "R9 old base");
    pixels(2, "R9 new base");

    // R7: mid-row window write restarts
    pixels(1, "R4 mid row");
    wr(8'h05, 8'h00);
    pixels(2, "R7 reload mid row");

    // R10: high bytes of edges and stride
    wr(8'h0B, 8'h00); wr(8'h0C, 8'h00); wr(8'h0A, 8'h00);
    wr(8'h00, 8'h7E); wr(8'h01, 8'h02);
    wr(8'h02, 8'h7F); wr(8'h03, 8'h02);
    wr(8'h04, 8'h05); wr(8'h05, 8'h01);
    wr(8'h06, 8'h06); wr(8'h07, 8'h01);
    wr(8'h09, 8'h02);
    pixels(5, "R10 high byte fields");
    idle_check("R2 final quiet");

    repeat (3) @(negedge clk);
    check(q_addr.size() == 0, "R2 missing writes", q_addr.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule